// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a segment:offset pair into a flat memory address, the way a real-mode segmented processor does. The offset, called the effective address, is the 16-bit sum of an optional base register, an optional index register and a signed displacement. The displacement is either 8 or 16 bits wide and is sign-extended before the add. The selected segment value is shifted left by four bits and added to the effective address, which gives a 20-bit physical address in a 1 MB space. Each segment opens a 64 KB window into that space.

An address unit presents one request per cycle with `in_valid`. One clock later the block returns the effective address, the physical address and a two-bit code for the segment it used. Both sums wrap: the effective address wraps at 64K and the physical address wraps at 1 MB. Because of this, many segment:offset pairs can reach the same byte.

Top module: `seg_addr_gen`

## Requirements
- R1: With `disp_wide` = 0 only `disp[7:0]` is used, sign-extended from bit 7. For example 80h becomes FF80h, and bits 15:8 of `disp` have no effect.
- R2: With `disp_wide` = 1 all 16 bits of `disp` are used as a two's-complement value.
- R3: `ea` equals the sum of the enabled base term, the enabled index term and the extended displacement, modulo 2^16. The carry out of bit 15 is dropped.
- R4: A term whose enable (`base_en`, `index_en`) is 0 is left out of the sum. With both enables at 0, `ea` equals the extended displacement alone.
- R5: `phys` equals (selected segment × 16 + `ea`) modulo 2^20. For example FFFF:0010 gives 00000h.
- R6: `seg_sel` picks the segment, and `seg_status` reports the same two-bit code: 00 extra, 01 stack, 10 code, 11 data.
- R7: The pairs 1000:1170, 1100:0170, 1110:0070 and 1117:0000 all yield physical address 11170h.
- R8: With data segment 1100h, index 0500h and an 8-bit displacement of -126 (82h), `ea` is 0482h and `phys` is 11482h.
- R9: `out_valid` equals `in_valid` of the previous cycle. The results of a request appear in the same cycle as its `out_valid`.
- R10: While `in_valid` is 0, `ea`, `phys` and `seg_status` hold their last values, whatever the other inputs do.
- R11: While reset is active, all outputs are 0, even when `in_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized inside |
| in_valid | input | 1 | Request strobe |
| seg_sel | input | 2 | Segment choice: 00 extra, 01 stack, 10 code, 11 data |
| seg_code | input | 16 | Code segment value |
| seg_data | input | 16 | Data segment value |
| seg_stack | input | 16 | Stack segment value |
| seg_extra | input | 16 | Extra segment value |
| base_val | input | 16 | Base register value |
| base_en | input | 1 | Include base term |
| index_val | input | 16 | Index register value |
| index_en | input | 1 | Include index term |
| disp | input | 16 | Displacement, short form in bits 7:0 |
| disp_wide | input | 1 | 1: 16-bit displacement, 0: 8-bit |
| out_valid | output | 1 | Result valid, one cycle after the request |
| ea | output | 16 | Effective address |
| phys | output | 20 | Physical address |
| seg_status | output | 2 | Code of the segment used |

## Verification
The bench builds the block with its default widths: 16-bit segment and offset, an 8-bit short displacement and a 4-bit shift. With these values the 20-bit wrap and the 16-bit wrap can both be reached with plain corner values such as FFFF:0010 and FFFFh + 0001h. The same widths cover the worked aliasing pairs and the -126 example exactly. Random requests mix the enable combinations, both displacement widths and idle cycles, so the hold behaviour and every segment code are exercised many times.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int DEF_SEG_W   = 16;
  localparam int DEF_OFF_W   = 16;
  localparam int DEF_SHORT_W = 8;
  localparam int DEF_SHIFT   = 4;

  // The encoding is the status code seen by the bus side
  typedef enum logic [1:0] {
    SEG_EXTRA = 2'b00,
    SEG_STACK = 2'b01,
    SEG_CODE  = 2'b10,
    SEG_DATA  = 2'b11
  } seg_sel_e;
endpackage

// File: rtl/sa_disp_ext.sv
module sa_disp_ext #(
  parameter int OFF_W   = 16,
  parameter int SHORT_W = 8
) (
  input  logic [OFF_W-1:0] disp_in,
  input  logic             wide,
  output logic [OFF_W-1:0] disp_ext
);
  localparam int PAD_W = OFF_W - SHORT_W;

  logic [OFF_W-1:0] short_ext;

  // Short form: replicate the sign bit of the low field
  assign short_ext = {{PAD_W{disp_in[SHORT_W-1]}}, disp_in[SHORT_W-1:0]};

  always_comb begin
    if (wide) disp_ext = disp_in;
    else      disp_ext = short_ext;
  end
endmodule

// File: rtl/sa_offset_sum.sv
module sa_offset_sum #(
  parameter int OFF_W = 16
) (
  input  logic [OFF_W-1:0] base_val,
  input  logic             base_en,
  input  logic [OFF_W-1:0] index_val,
  input  logic             index_en,
  input  logic [OFF_W-1:0] disp_ext,
  output logic [OFF_W-1:0] ea
);
  logic [OFF_W-1:0] base_term;
  logic [OFF_W-1:0] index_term;

  always_comb begin
    base_term  = base_en  ? base_val  : '0;
    index_term = index_en ? index_val : '0;
    // Sum kept at OFF_W bits: carry out of the top bit is dropped
    ea = base_term + index_term + disp_ext;
  end
endmodule

// File: rtl/sa_seg_pick.sv
module sa_seg_pick #(
  parameter int SEG_W = 16
) (
  input  logic [3:0][SEG_W-1:0] seg_vals,
  input  logic [1:0]            sel,
  output logic [SEG_W-1:0]      seg_out
);
  // seg_vals is packed so that the index equals the status code
  always_comb seg_out = seg_vals[sel];
endmodule

// File: rtl/sa_phys_add.sv
module sa_phys_add #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4
) (
  input  logic [SEG_W-1:0]       seg_val,
  input  logic [OFF_W-1:0]       ea,
  output logic [SEG_W+SHIFT-1:0] phys
);
  localparam int PHYS_W = SEG_W + SHIFT;
  localparam int ZPAD_W = PHYS_W - OFF_W;

  logic [PHYS_W-1:0] seg_shifted;
  logic [PHYS_W-1:0] off_ext;

  assign seg_shifted = {seg_val, {SHIFT{1'b0}}};
  assign off_ext     = {{ZPAD_W{1'b0}}, ea};
  // Wraps at PHYS_W bits
  assign phys        = seg_shifted + off_ext;
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int SEG_W   = DEF_SEG_W,
  parameter int OFF_W   = DEF_OFF_W,
  parameter int SHORT_W = DEF_SHORT_W,
  parameter int SHIFT   = DEF_SHIFT
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [1:0]             seg_sel,
  input  logic [SEG_W-1:0]       seg_code,
  input  logic [SEG_W-1:0]       seg_data,
  input  logic [SEG_W-1:0]       seg_stack,
  input  logic [SEG_W-1:0]       seg_extra,
  input  logic [OFF_W-1:0]       base_val,
  input  logic                   base_en,
  input  logic [OFF_W-1:0]       index_val,
  input  logic                   index_en,
  input  logic [OFF_W-1:0]       disp,
  input  logic                   disp_wide,
  output logic                   out_valid,
  output logic [OFF_W-1:0]       ea,
  output logic [SEG_W+SHIFT-1:0] phys,
  output logic [1:0]             seg_status
);
  localparam int PHYS_W = SEG_W + SHIFT;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  // Datapath
  logic [OFF_W-1:0]       disp_x;
  logic [OFF_W-1:0]       ea_c;
  logic [SEG_W-1:0]       seg_c;
  logic [PHYS_W-1:0]      phys_c;
  logic [3:0][SEG_W-1:0]  seg_vec;

  assign seg_vec = {seg_data, seg_code, seg_stack, seg_extra};

  sa_disp_ext #(.OFF_W(OFF_W), .SHORT_W(SHORT_W)) u_disp (
    .disp_in (disp),
    .wide    (disp_wide),
    .disp_ext(disp_x)
  );

  sa_offset_sum #(.OFF_W(OFF_W)) u_off (
    .base_val (base_val),
    .base_en  (base_en),
    .index_val(index_val),
    .index_en (index_en),
    .disp_ext (disp_x),
    .ea       (ea_c)
  );

  sa_seg_pick #(.SEG_W(SEG_W)) u_pick (
    .seg_vals(seg_vec),
    .sel     (seg_sel),
    .seg_out (seg_c)
  );

  sa_phys_add #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_phys (
    .seg_val(seg_c),
    .ea     (ea_c),
    .phys   (phys_c)
  );

  // Next state
  logic              load_en;
  logic              vld_d,  vld_q;
  logic [OFF_W-1:0]  ea_d,   ea_q;
  logic [PHYS_W-1:0] phys_d, phys_q;
  seg_sel_e          stat_d, stat_q;

  assign load_en = in_valid;

  always_comb begin
    vld_d  = in_valid;
    ea_d   = ea_q;
    phys_d = phys_q;
    stat_d = stat_q;
    if (load_en) begin
      ea_d   = ea_c;
      phys_d = phys_c;
      stat_d = seg_sel_e'(seg_sel);
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      vld_q  <= 1'b0;
      ea_q   <= '0;
      phys_q <= '0;
      stat_q <= SEG_EXTRA;
    end else begin
      vld_q  <= vld_d;
      ea_q   <= ea_d;
      phys_q <= phys_d;
      stat_q <= stat_d;
    end
  end

  assign out_valid  = vld_q;
  assign ea         = ea_q;
  assign phys       = phys_q;
  assign seg_status = stat_q;
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int OFF_W  = 16,
  parameter int PHYS_W = 20,
  parameter int SHIFT  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        seg_sel,
  input logic              out_valid,
  input logic [OFF_W-1:0]  ea,
  input logic [PHYS_W-1:0] phys,
  input logic [1:0]        seg_status
);
  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R9
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(ea) && $stable(phys) && $stable(seg_status)));

  // R6
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (seg_status == $past(seg_sel)));

  // R5
  low_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (phys[SHIFT-1:0] == ea[SHIFT-1:0]));
endmodule

bind seg_addr_gen seg_addr_gen_chk #(
  .OFF_W (OFF_W),
  .PHYS_W(SEG_W + SHIFT),
  .SHIFT (SHIFT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .in_valid  (in_valid),
  .seg_sel   (seg_sel),
  .out_valid (out_valid),
  .ea        (ea),
  .phys      (phys),
  .seg_status(seg_status)
);

// File: tb/seg_addr_gen_bench.sv
module seg_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  seg_sel;
  logic [15:0] seg_code, seg_data, seg_stack, seg_extra;
  logic [15:0] base_val, index_val, disp;
  logic        base_en, index_en, disp_wide;
  logic        out_valid;
  logic [15:0] ea;
  logic [19:0] phys;
  logic [1:0]  seg_status;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  seg_addr_gen u_seg_addr_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .seg_sel(seg_sel),
    .seg_code(seg_code), .seg_data(seg_data), .seg_stack(seg_stack),
    .seg_extra(seg_extra), .base_val(base_val), .base_en(base_en),
    .index_val(index_val), .index_en(index_en), .disp(disp),
    .disp_wide(disp_wide), .out_valid(out_valid), .ea(ea), .phys(phys),
    .seg_status(seg_status)
  );

  function automatic logic [15:0] exp_ea(logic [15:0] b, logic be,
      logic [15:0] i, logic ie, logic [15:0] d, logic w);
    logic [15:0] dx;
    logic [15:0] s;
    dx = w ? d : {{8{d[7]}}, d[7:0]};
    s  = (be ? b : 16'h0) + (ie ? i : 16'h0) + dx;
    return s;
  endfunction

  function automatic logic [19:0] exp_phys(logic [15:0] sg, logic [15:0] e);
    logic [20:0] t;
    t = {1'b0, sg, 4'h0} + {5'h0, e};
    return t[19:0];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [19:0] act, input logic [19:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic set_segs(input logic [15:0] c, input logic [15:0] d,
                          input logic [15:0] s, input logic [15:0] x);
    seg_code = c; seg_data = d; seg_stack = s; seg_extra = x;
  endtask

  // Drive at a falling edge, check at the falling edge after capture
  task automatic txn(input string req, input logic [1:0] sel,
      input logic [15:0] b, input logic be, input logic [15:0] i,
      input logic ie, input logic [15:0] d, input logic w);
    logic [15:0] sg, e;
    logic [19:0] p;
    @(negedge clk);
    seg_sel = sel; base_val = b; base_en = be; index_val = i;
    index_en = ie; disp = d; disp_wide = w; in_valid = 1'b1;
    case (sel)
      2'b00: sg = seg_extra;
      2'b01: sg = seg_stack;
      2'b10: sg = seg_code;
      default: sg = seg_data;
    endcase
    e = exp_ea(b, be, i, ie, d, w);
    p = exp_phys(sg, e);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R9", "out_valid", {19'h0, out_valid}, 20'h1);
    chk(ea == e, req, "ea", {4'h0, ea}, {4'h0, e});
    chk(phys == p, req, "phys", phys, p);
    chk(seg_status == sel, "R6", "seg_status", {18'h0, seg_status}, {18'h0, sel});
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] h_ea;
    logic [19:0] h_ph;
    logic [1:0]  h_st;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0;
    in_valid = 1'b1;
    seg_sel = 2'b11;
    set_segs(16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0);
    base_val = 16'h1111; index_val = 16'h2222; disp = 16'h0033;
    base_en = 1'b1; index_en = 1'b1; disp_wide = 1'b1;
    repeat (4) @(negedge clk);
    // R11: outputs stay clear while reset is held, even with a request
    chk(out_valid == 1'b0, "R11", "out_valid", {19'h0, out_valid}, 20'h0);
    chk(ea == 16'h0, "R11", "ea", {4'h0, ea}, 20'h0);
    chk(phys == 20'h0, "R11", "phys", phys, 20'h0);
    chk(seg_status == 2'b00, "R11", "seg_status", {18'h0, seg_status}, 20'h0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R8: worked example with data segment
    set_segs(16'h0000, 16'h1100, 16'h0000, 16'h0000);
    txn("R8", 2'b11, 16'h0, 1'b0, 16'h0500, 1'b1, 16'h0082, 1'b0);
    chk(ea == 16'h0482, "R8", "ea literal", {4'h0, ea}, 20'h00482);
    chk(phys == 20'h11482, "R8", "phys literal", phys, 20'h11482);

    // R7: aliasing pairs, offset carried in the base term
    set_segs(16'h1000, 16'h1100, 16'h1110, 16'h1117);
    txn("R7", 2'b10, 16'h1170, 1'b1, 16'h0, 1'b0, 16'h0, 1'b1);
    chk(phys == 20'h11170, "R7", "1000:1170", phys, 20'h11170);
    txn("R7", 2'b11, 16'h0170, 1'b1, 16'h0, 1'b0, 16'h0, 1'b1);
    chk(phys == 20'h11170, "R7", "1100:0170", phys, 20'h11170);
    txn("R7", 2'b01, 16'h0070, 1'b1, 16'h0, 1'b0, 16'h0, 1'b1);
    chk(phys == 20'h11170, "R7", "1110:0070", phys, 20'h11170);
    txn("R7", 2'b00, 16'h0, 1'b0, 16'h0, 1'b0, 16'h0, 1'b1);
    chk(phys == 20'h11170, "R7", "1117:0000", phys, 20'h11170);

    // R5: 20-bit wrap
    set_segs(16'hFFFF, 16'h0, 16'h0, 16'h0);
    txn("R5", 2'b10, 16'h0010, 1'b1, 16'h0, 1'b0, 16'h0, 1'b1);
    chk(phys == 20'h00000, "R5", "FFFF:0010", phys, 20'h00000);

    // R3: 16-bit wrap of the offset
    set_segs(16'h0, 16'h2000, 16'h0, 16'h0);
    txn("R3", 2'b11, 16'hFFFF, 1'b1, 16'h0001, 1'b1, 16'h0, 1'b1);
    chk(ea == 16'h0000, "R3", "FFFF+0001", {4'h0, ea}, 20'h0);
    chk(phys == 20'h20000, "R3", "wrap phys", phys, 20'h20000);

    // R1: short displacement, upper bits must not matter
    txn("R1", 2'b11, 16'h0100, 1'b1, 16'h0, 1'b0, 16'hAB80, 1'b0);
    chk(ea == 16'h0080, "R1", "0100+sext(80)", {4'h0, ea}, 20'h00080);
    // R2: wide displacement
    txn("R2", 2'b11, 16'h0100, 1'b1, 16'h0, 1'b0, 16'hAB80, 1'b1);
    chk(ea == 16'hAC80, "R2", "0100+AB80", {4'h0, ea}, 20'h0AC80);

    // R4: enables
    txn("R4", 2'b11, 16'h1000, 1'b0, 16'h0200, 1'b0, 16'h0030, 1'b1);
    chk(ea == 16'h0030, "R4", "direct", {4'h0, ea}, 20'h00030);
    txn("R4", 2'b11, 16'h1000, 1'b1, 16'h0200, 1'b0, 16'h0030, 1'b1);
    chk(ea == 16'h1030, "R4", "base only", {4'h0, ea}, 20'h01030);
    txn("R4", 2'b11, 16'h1000, 1'b0, 16'h0200, 1'b1, 16'h0030, 1'b1);
    chk(ea == 16'h0230, "R4", "index only", {4'h0, ea}, 20'h00230);

    // R6: each segment code picks its own register
    set_segs(16'hC000, 16'hD000, 16'h5000, 16'hE000);
    for (int s = 0; s < 4; s++)
      txn("R6", s[1:0], 16'h0004, 1'b1, 16'h0, 1'b0, 16'h0, 1'b1);

    // R10: idle cycles with changing inputs leave outputs alone
    h_ea = ea; h_ph = phys; h_st = seg_status;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      seg_sel = k[1:0]; base_val = $urandom(); index_val = $urandom();
      disp = $urandom(); set_segs($urandom(), $urandom(), $urandom(), $urandom());
    end
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", "idle out_valid", {19'h0, out_valid}, 20'h0);
    chk(ea == h_ea, "R10", "hold ea", {4'h0, ea}, {4'h0, h_ea});
    chk(phys == h_ph, "R10", "hold phys", phys, h_ph);
    chk(seg_status == h_st, "R10", "hold status", {18'h0, seg_status}, {18'h0, h_st});

    // Random mix against the reference formula (R3, R5)
    for (int n = 0; n < 400; n++) begin
      set_segs($urandom(), $urandom(), $urandom(), $urandom());
      txn("R3/R5", 2'($urandom()), 16'($urandom()), 1'($urandom()),
          16'($urandom()), 1'($urandom()), 16'($urandom()), 1'($urandom()));
      if (($urandom() & 3) == 0) @(negedge clk);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule